// File: doc/BRIEF.md
# Configurable Master/Slave Serial Shifter

This block is an 8-bit synchronous serial shift unit that sits behind a processor's register writes. Software writes a configuration word (master clock rate, bit order, sampling edge, interrupt enable), a transmit byte and a control word (Start, master/slave mode, Status). Setting Start arms exactly eight shifts. On each one a bit is taken from the serial data input into the shift register and the byte loaded beforehand leaves on the serial data output. Once the transfer is done, Start clears itself and an interrupt flag is raised. Software then reads the received byte back from the shift register.

In master mode the shift clock is made from the system clock through a divider, and it stays low whenever no transfer is armed. In slave mode the shift clock and the data come from pins. They pass through a two-flop synchronizer, so the external clock must run at no more than a quarter of the system clock. Clock edges that arrive while Start is low are ignored. A ready/select output reports Start OR Status. It can tell an external master that the unit is armed, or it can act as a select line for an external slave.

Top module: `sshift_unit`

## Requirements
- R1: After reset, Start, Status, the interrupt flag and the shift register are 0 and the unit is in slave mode. The clock, data and ready outputs all have their enables at 0. The configuration defaults to LSB-first order with sampling on the falling edge, so a transfer run without any configuration write behaves that way.
- R2: A write of the control register with Start=1 arms exactly eight shifts. The k-th sampled input bit (k=0..7) lands in shift register bit k when cfg_msb_first=0 and in bit 7-k when cfg_msb_first=1. The k-th output bit is bit k, or bit 7-k, of the transmit byte in the same way.
- R3: The eighth falling edge of the shift clock ends the transfer in either mode. On the system clock edge that processes it, Start returns to 0 and irq_flag_o becomes 1. irq_o equals irq_flag_o AND cfg_irq_en.
- R4: While Start is 0, edges on sclk_in and data on sdi_in change neither the shift register nor the interrupt flag.
- R5: In master mode the shift clock has a half period of 1, 2 or 4 system clock cycles for cfg_div = 0, 1 or 2; code 3 behaves like code 2. The clock first rises that many cycles after the Start write. sclk_out is 0 whenever Start has been 0 for at least one cycle.
- R6: rdy_out always equals Start OR Status. rdy_oe is 0 until the first control write and 1 afterwards.
- R7: Any control register write clears the interrupt flag. With cfg_irq_en=0, irq_o stays 0 even while the flag is set.
- R8: With cfg_rise_sample=1 input data is sampled on rising shift clock edges. With cfg_rise_sample=0 it is sampled on falling edges.
- R9: sdo_out changes only on the shift clock edge opposite to the sampling edge, so it is stable at every sampling edge.
- R10: A Start=1 write during a transfer restarts the count of eight and reloads the shift register from the transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_div | input | 2 | Master clock rate code (0: /2, 1: /4, 2 and 3: /8) |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_rise_sample | input | 1 | 1 = sample on rising edge, 0 = on falling edge |
| cfg_irq_en | input | 1 | Interrupt enable (0 masks irq_o) |
| data_we | input | 1 | Transmit byte write strobe |
| data_wr | input | 8 | Transmit byte |
| ctl_we | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start value written |
| ctl_master | input | 1 | 1 = master mode, 0 = slave mode |
| ctl_status | input | 1 | Status value written |
| sclk_in | input | 1 | External shift clock (slave mode) |
| sdi_in | input | 1 | Serial data input |
| sclk_out | output | 1 | Generated shift clock (master mode) |
| sclk_oe | output | 1 | Output enable of sclk_out |
| sdo_out | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable of sdo_out |
| rdy_out | output | 1 | Start OR Status |
| rdy_oe | output | 1 | Output enable of rdy_out |
| start_o | output | 1 | Current Start bit |
| rx_data_o | output | 8 | Shift register contents |
| irq_flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request after the enable |

## Verification
Register writes take effect on the clock edge where the strobe is high. The bench samples every result at the falling edge after that edge. In master mode a bit is due on the same system edge where sclk_out changes, so the bench follows sclk_out at falling system edges, reads sdo_out there and changes sdi_in before the next shift edge, which is at least two cycles away. In slave mode a pin edge acts on the third system edge after it, so the bench holds each slave clock phase for four cycles and reads sdo_out just before it drives the next pin edge. After the last falling edge it waits four cycles before checking Start, the interrupt flag and the received byte.

// File: rtl/ss_pkg.sv
// Shared types for the serial shifter: configuration word and divider decode.
package ss_pkg;

    localparam int DIV_SEL_W = 2;

    // Configuration register contents.
    typedef struct packed {
        logic [DIV_SEL_W-1:0] div;
        logic                 msb_first;
        logic                 rise_sample;
        logic                 irq_en;
    } ss_cfg_t;

    // Half period minus one, in system cycles, for a rate code (3 aliases 2).
    function automatic int unsigned half_m1(input logic [DIV_SEL_W-1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 1;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/ss_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes: inputs are slow against clk; all bits share the same latency.
module ss_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            // Later flops settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ss_clkgen.sv
// Master shift clock generator: divides clk by 2, 4 or 8 while run_i is high.
// Assumes: CNT_W is wide enough for the largest half period (4 -> 2 bits).
// The clock idles low; restart_i forces it low and restarts the count.
module ss_clkgen #(
    parameter int CNT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_i,
    input  logic                        restart_i,
    input  logic [ss_pkg::DIV_SEL_W-1:0] div_i,
    output logic                        sclk_o,
    output logic                        rise_o,
    output logic                        fall_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             sclk_q;
    logic             tick;

    // Decode the rate code into the terminal count.
    always_comb limit = CNT_W'(ss_pkg::half_m1(div_i));

    assign tick   = run_i && !restart_i && (cnt_q == limit);
    assign rise_o = tick && !sclk_q;
    assign fall_o = tick && sclk_q;
    assign sclk_o = sclk_q;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R5

endmodule

// File: rtl/ss_shreg.sv
// Shift register, output bit flop and shift counter of the serial shifter.
// Assumes: sample_i and drive_i never coincide; count_i marks falling
// shift clock edges; load_i has priority over every event.
module ss_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         msb_first_i,
    input  logic         sample_i,
    input  logic         drive_i,
    input  logic         count_i,
    input  logic         sdi_i,
    output logic [W-1:0] sr_o,
    output logic         sdo_o,
    output logic         done_o
);

    localparam int CNT_W = $clog2(W);

    logic [W-1:0]     sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sdo_q;
    logic             next_out;
    logic             first_out;

    assign next_out  = msb_first_i ? sr_q[W-1] : sr_q[0];
    assign first_out = msb_first_i ? load_data_i[W-1] : load_data_i[0];
    assign done_o    = count_i && (cnt_q == CNT_W'(W-1));
    assign sr_o      = sr_q;
    assign sdo_o     = sdo_q;

    // Load, shift-in on sampling edges, drive out on the opposite edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
            sdo_q <= 1'b0;
        end else if (load_i) begin
            sr_q  <= load_data_i;
            cnt_q <= '0;
            sdo_q <= first_out;
        end else begin
            if (sample_i)
                sr_q <= msb_first_i ? {sr_q[W-2:0], sdi_i} : {sdi_i, sr_q[W-1:1]};
            if (drive_i)
                sdo_q <= next_out;
            if (count_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i && !load_i |=> $stable(sdo_q)); // R9

endmodule

// File: rtl/sshift_unit.sv
// Top of the configurable master/slave serial shifter.
// Holds the configuration, transmit and control registers, selects the
// master or slave shift clock, and raises the interrupt flag after 8 shifts.
// Assumes: in slave mode sclk_in idles low and runs at most at clk/4.
module sshift_unit #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_div,
    input  logic              cfg_msb_first,
    input  logic              cfg_rise_sample,
    input  logic              cfg_irq_en,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wr,
    input  logic              ctl_we,
    input  logic              ctl_start,
    input  logic              ctl_master,
    input  logic              ctl_status,
    input  logic              sclk_in,
    input  logic              sdi_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic              rdy_out,
    output logic              rdy_oe,
    output logic              start_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              irq_flag_o,
    output logic              irq_o
);

    import ss_pkg::*;

    ss_cfg_t           cfg_q;
    logic [DATA_W-1:0] data_q;
    logic              start_q, master_q, status_q, irq_q, drv_en_q;
    logic [1:0]        pins_s;
    logic              s_sclk_d;
    logic              s_rise, s_fall, m_rise, m_fall, m_sclk;
    logic              rise_ev, fall_ev, sample_ev, drive_ev;
    logic              sdi_sel, load, done_ev;

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= '{div: cfg_div, msb_first: cfg_msb_first,
                                    rise_sample: cfg_rise_sample, irq_en: cfg_irq_en};
    end

    // Transmit byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (data_we) data_q <= data_wr;
    end

    // Control register with self-clearing Start and the interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            master_q <= 1'b0;
            status_q <= 1'b0;
            irq_q    <= 1'b0;
            drv_en_q <= 1'b0;
        end else if (ctl_we) begin
            start_q  <= ctl_start;
            master_q <= ctl_master;
            status_q <= ctl_status;
            irq_q    <= 1'b0;
            drv_en_q <= 1'b1;
        end else if (done_ev) begin
            start_q  <= 1'b0;
            irq_q    <= 1'b1;
        end
    end

    ss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_in, sdi_in}),
        .q_o   (pins_s)
    );

    // Delayed copy of the synchronized slave clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) s_sclk_d <= 1'b0;
        else        s_sclk_d <= pins_s[1];
    end

    assign s_rise = pins_s[1] && !s_sclk_d;
    assign s_fall = !pins_s[1] && s_sclk_d;

    ss_clkgen #(.CNT_W(DIV_CNT_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (start_q && master_q),
        .restart_i (load),
        .div_i     (cfg_q.div),
        .sclk_o    (m_sclk),
        .rise_o    (m_rise),
        .fall_o    (m_fall)
    );

    assign load      = ctl_we && ctl_start;
    assign rise_ev   = start_q && (master_q ? m_rise : s_rise);
    assign fall_ev   = start_q && (master_q ? m_fall : s_fall);
    assign sample_ev = cfg_q.rise_sample ? rise_ev : fall_ev;
    assign drive_ev  = cfg_q.rise_sample ? fall_ev : rise_ev;
    assign sdi_sel   = master_q ? sdi_in : pins_s[0];

    ss_shreg #(.W(DATA_W)) u_shreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_data_i (data_q),
        .msb_first_i (cfg_q.msb_first),
        .sample_i    (sample_ev),
        .drive_i     (drive_ev),
        .count_i     (fall_ev),
        .sdi_i       (sdi_sel),
        .sr_o        (rx_data_o),
        .sdo_o       (sdo_out),
        .done_o      (done_ev)
    );

    assign sclk_out   = master_q && m_sclk;
    assign sclk_oe    = master_q;
    assign sdo_oe     = start_q;
    assign rdy_out    = start_q || status_q;
    assign rdy_oe     = drv_en_q;
    assign start_o    = start_q;
    assign irq_flag_o = irq_q;
    assign irq_o      = irq_q && cfg_q.irq_en;

    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_ev && !ctl_we |=> !start_q); // R3
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done_ev && !ctl_we |=> irq_q); // R3
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q && !ctl_we |=> $stable(rx_data_o)); // R4
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q && !$past(start_q) |-> !sclk_out); // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rx_data_o == $past(data_q)); // R10

endmodule

// File: tb/sim_sshift_unit.sv
`timescale 1ns/1ps
module sim_sshift_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 0, cfg_msb_first = 0, cfg_rise_sample = 0, cfg_irq_en = 0;
    logic [1:0] cfg_div = 0;
    logic       data_we = 0;
    logic [7:0] data_wr = 0;
    logic       ctl_we = 0, ctl_start = 0, ctl_master = 0, ctl_status = 0;
    logic       sclk_in = 0, sdi_in = 0;
    logic       sclk_out, sclk_oe, sdo_out, sdo_oe, rdy_out, rdy_oe, start_o;
    logic [7:0] rx_data_o;
    logic       irq_flag_o, irq_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sshift_unit u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Map the k-th bit of a serial stream to its byte position.
    function automatic logic [7:0] place(input logic [7:0] stream, input logic msb);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[msb ? 7 - k : k] = stream[k];
        return r;
    endfunction

    function automatic int half_of(input logic [1:0] div);
        return (div == 2'd0) ? 1 : (div == 2'd1) ? 2 : 4;
    endfunction

    task automatic wr_cfg(input logic [1:0] div, input logic msb, input logic rs, input logic en);
        @(negedge clk);
        cfg_we = 1; cfg_div = div; cfg_msb_first = msb; cfg_rise_sample = rs; cfg_irq_en = en;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(negedge clk);
        data_we = 1; data_wr = d;
        @(negedge clk);
        data_we = 0;
    endtask

    task automatic wr_ctl(input logic st, input logic ms, input logic stat);
        @(negedge clk);
        ctl_we = 1; ctl_start = st; ctl_master = ms; ctl_status = stat;
        @(negedge clk);
        ctl_we = 0;
    endtask

    // Master transfer: follow sclk_out, feed sdi_in, collect sdo_out.
    task automatic run_master(input logic [7:0] d, input logic [7:0] bits, input logic [1:0] div,
                              input logic msb, input logic rs, input logic en, input string tag);
        logic [7:0] got = 0;
        int k = 0, cyc = 0, r0 = -1, r1 = -1, guard = 0;
        logic prev;
        wr_cfg(div, msb, rs, en);
        wr_data(d);
        sdi_in = bits[0];
        wr_ctl(1, 1, 0);
        chk({tag, " R6 rdy while armed"}, rdy_out, 1);
        prev = sclk_out;
        while (!(k == 8 && !start_o) && guard < 400) begin
            @(negedge clk);
            cyc++; guard++;
            if (sclk_out !== prev) begin
                prev = sclk_out;
                if (sclk_out) begin
                    if (r0 < 0) r0 = cyc; else if (r1 < 0) r1 = cyc;
                end
                if (sclk_out == rs && k < 8) begin
                    got[k] = sdo_out;
                    k++;
                    if (k < 8) sdi_in = bits[k];
                end
            end
        end
        repeat (2) @(negedge clk);
        chk({tag, " R5 master period"}, r1 - r0, 2 * half_of(div));
        chk({tag, " R2/R8 rx byte"}, rx_data_o, place(bits, msb));
        chk({tag, " R9 tx bits"}, place(got, msb), d);
        chk({tag, " R3 start cleared"}, start_o, 0);
        chk({tag, " R3 irq flag"}, irq_flag_o, 1);
        chk({tag, " R7 irq out/mask"}, irq_o, en);
        chk({tag, " R5 clock low idle"}, sclk_out, 0);
    endtask

    // Slave transfer: bench drives sclk_in with 4-cycle phases.
    task automatic run_slave(input logic [7:0] d, input logic [7:0] bits, input logic msb,
                             input logic rs, input logic en, input logic do_cfg, input string tag);
        logic [7:0] got = 0;
        if (do_cfg) wr_cfg(2'd0, msb, rs, en);
        wr_data(d);
        sdi_in = bits[0];
        sclk_in = 0;
        wr_ctl(1, 0, 0);
        for (int k = 0; k < 8; k++) begin
            repeat (4) @(negedge clk);
            if (!rs) begin
                if (k > 0) sdi_in = bits[k];
            end else begin
                got[k] = sdo_out;
            end
            sclk_in = 1;
            repeat (4) @(negedge clk);
            if (rs) begin
                if (k < 7) sdi_in = bits[k+1];
            end else begin
                got[k] = sdo_out;
            end
            sclk_in = 0;
        end
        repeat (4) @(negedge clk);
        chk({tag, " R2/R8 rx byte"}, rx_data_o, place(bits, msb));
        chk({tag, " R9 tx bits"}, place(got, msb), d);
        chk({tag, " R3 start cleared"}, start_o, 0);
        chk({tag, " R3 irq flag"}, irq_flag_o, 1);
        chk({tag, " R7 irq out/mask"}, irq_o, en);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 start", start_o, 0);
        chk("R1 irq flag", irq_flag_o, 0);
        chk("R1 oe all zero", {sclk_oe, sdo_oe, rdy_oe}, 3'b000);
        chk("R1 rx zero", rx_data_o, 0);
        chk("R1 ready low", rdy_out, 0);
        // R1 defaults: LSB first, falling sample, slave, no cfg write
        run_slave(8'hA5, 8'h3C, 0, 0, 0, 0, "R1 default");
        chk("R1 rdy_oe after ctl write", rdy_oe, 1);

        // R7 clear by control write, R6 status
        wr_ctl(0, 0, 1);
        chk("R7 irq cleared", irq_flag_o, 0);
        chk("R6 status only", rdy_out, 1);
        wr_ctl(0, 0, 0);
        chk("R6 both low", rdy_out, 0);

        // R4 idle edges ignored
        keep = rx_data_o;
        for (int i = 0; i < 10; i++) begin
            sdi_in = 1'($urandom);
            repeat (4) @(negedge clk);
            sclk_in = ~sclk_in;
        end
        sclk_in = 0;
        repeat (4) @(negedge clk);
        chk("R4 rx unchanged", rx_data_o, keep);
        chk("R4 irq unchanged", irq_flag_o, 0);
        chk("R4 start still low", start_o, 0);

        // Directed master corners: every rate code, both orders and edges
        run_master(8'h81, 8'hF0, 2'd0, 0, 0, 1, "R5 div2");
        run_master(8'h5A, 8'h0F, 2'd1, 1, 1, 0, "R5 div4");
        run_master(8'hC3, 8'h96, 2'd2, 0, 1, 1, "R5 div8");
        run_master(8'h17, 8'hE1, 2'd3, 1, 0, 1, "R5 code3");
        run_slave(8'h69, 8'hB4, 1, 1, 1, 1, "R8 slave rise msb");

        // R10 restart in mid-transfer
        wr_cfg(2'd2, 0, 0, 1);
        wr_data(8'hFF);
        wr_ctl(1, 1, 0);
        repeat (20) @(negedge clk);
        chk("R10 still busy before restart", start_o, 1);
        run_master(8'h3E, 8'h71, 2'd2, 0, 0, 1, "R10 restart");

        // Random mix
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d, b;
            logic [1:0] dv;
            logic m, rs, ms, en;
            d = 8'($urandom); b = 8'($urandom); dv = 2'($urandom);
            m = 1'($urandom); rs = 1'($urandom); ms = 1'($urandom); en = 1'($urandom);
            if (m) run_master(d, b, dv, ms, rs, en, "R2 rand master");
            else   run_slave(d, b, ms, rs, en, 1, "R2 rand slave");
        end

        summary();
        $finish;
    end

endmodule